// File: doc/BRIEF.md
# Smart-Card Character Error-Signal Controller

This block sits next to a smart-card receiver that runs the character protocol with per-character error signalling. After each received character it decides whether to pull the shared I/O line low as a negative acknowledge. It counts consecutive bad-parity characters against a programmable ceiling. Once the ceiling is reached it stops signalling and raises a sticky flag. The receiver hands it one event per character, made of a parity-error bit, over a valid/ready pair. A half-unit tick from the baud generator times the low pulse.

Back-pressure works as follows. `char_ready` drops in the cycle after a character that needs a negative acknowledge is accepted. It stays low until the pulse on the line has ended. While it is low, `char_valid` has no effect. Characters that need no pulse leave `char_ready` high, so the next event may follow in the next cycle. The controls `inhibit_nack`, `limit_en` and `max_retries` are static levels. `clr_status` is a one-cycle command.

Top module: `nack_ctl`

## Requirements
- R1: After reset, `nack_drive` and `iter_flag` are 0 and `char_ready` is 1.
- R2: While `inhibit_nack` is 1, an accepted character with a parity error produces no pulse (`char_ready` stays 1), and it leaves the error count and `iter_flag` unchanged.
- R3: While `inhibit_nack` is 0 and `limit_en` is 0, every accepted character with a parity error produces a pulse, and `iter_flag` is never set.
- R4: While `inhibit_nack` is 0 and `limit_en` is 1, an accepted parity error produces a pulse and increments the count, as long as the count is below `max_retries` (3 bits, 0 to 7).
- R5: Under the same settings, an accepted parity error that finds the count equal to `max_retries` produces no pulse and sets `iter_flag`. With `max_retries` = 0 this applies to the very first error.
- R6: An accepted character without a parity error resets the count to 0 and produces no pulse.
- R7: The pulse (`nack_drive` = 1) starts on the LEAD_HALVES-th `half_tick` after acceptance (default 1). It lasts DRIVE_HALVES half ticks (default 2, one elementary time unit). A tick in the accepting cycle does not count.
- R8: `iter_flag` stays set until `clr_status`. `clr_status` zeroes both the flag and the count, and it takes effect before any character accepted in the same cycle.
- R9: `char_ready` is 0 from the cycle after a pulsing character is accepted until the cycle after the pulse ends. A character offered while it is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | A received character event is offered |
| char_ready | output | 1 | The block can take a character event |
| char_perr | input | 1 | The offered character had a parity error |
| inhibit_nack | input | 1 | Suppress all negative acknowledges |
| limit_en | input | 1 | Count successive errors against the ceiling |
| max_retries | input | 3 | Ceiling on successive signalled errors |
| half_tick | input | 1 | One-cycle pulse every half elementary time unit |
| clr_status | input | 1 | Clear the count and the sticky flag |
| nack_drive | output | 1 | Request to hold the I/O line low |
| iter_flag | output | 1 | Sticky: the error ceiling was reached |

## Verification
A count that is off by one is invisible on any single character. It shows up only at the ceiling, where the pulse is either missed or given once too often. For that reason the bench walks full error runs up to and past several ceilings, including 0 and 1. A corrupted timer state would shift or stretch `nack_drive` by a whole half tick. That is visible within one tick interval of acceptance, and `char_ready` would be held low too long or released too early. A busy controller that wrongly took a character would move the ceiling by one. That shows up on the next error run.

// File: rtl/nack_ctl_pkg.sv
package nack_ctl_pkg;

  typedef enum logic [1:0] {
    NK_IDLE  = 2'd0,
    NK_LEAD  = 2'd1,
    NK_DRIVE = 2'd2
  } nk_state_e;

  typedef struct packed {
    logic fire;       // a pulse must be driven for this character
    logic hit_limit;  // the ceiling was met by this character
  } nk_verdict_t;

endpackage

// File: rtl/nack_decide.sv
module nack_decide
  import nack_ctl_pkg::*;
#(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              perr,
  input  logic              inhibit,
  input  logic              limit_en,
  input  logic [ITER_W-1:0] max_iter,
  input  logic              clr,
  output nk_verdict_t       verdict,
  output logic              flag_o
);

  localparam logic [ITER_W-1:0] ZERO = '0;
  localparam logic [ITER_W-1:0] ONE  = ITER_W'(1);

  logic [ITER_W-1:0] cnt_q, cnt_eff, cnt_nx;
  logic              flag_q, flag_eff, flag_nx;

  always_comb begin
    // a same-cycle clear wins over the character
    cnt_eff   = clr ? ZERO : cnt_q;
    flag_eff  = clr ? 1'b0 : flag_q;
    cnt_nx    = cnt_eff;
    flag_nx   = flag_eff;
    verdict   = '0;
    if (take) begin
      if (!perr) begin
        cnt_nx = ZERO;
      end else if (!inhibit) begin
        if (!limit_en) begin
          verdict.fire = 1'b1;
        end else if (cnt_eff < max_iter) begin
          verdict.fire = 1'b1;
          cnt_nx       = cnt_eff + ONE;
        end else begin
          verdict.hit_limit = 1'b1;
          flag_nx           = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      flag_q <= flag_nx;
    end
  end

  assign flag_o = flag_q;

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && perr && !inhibit && limit_en && !clr && (cnt_q < max_iter)
    |=> cnt_q == $past(cnt_q) + ONE);

  p_limit_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && perr && !inhibit && limit_en && !clr && (cnt_q == max_iter)
    |=> flag_q && (cnt_q == $past(cnt_q)));

  p_inhibit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && perr && inhibit && !clr |=> $stable(cnt_q) && $stable(flag_q));

  p_good_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !perr |=> cnt_q == ZERO);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !take |=> !flag_q && cnt_q == ZERO);

endmodule

// File: rtl/nack_timer.sv
module nack_timer
  import nack_ctl_pkg::*;
#(
  parameter int LEAD_HALVES  = 1,
  parameter int DRIVE_HALVES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_tick,
  output logic busy,
  output logic drive_o
);

  localparam int MAXH = (LEAD_HALVES > DRIVE_HALVES) ? LEAD_HALVES : DRIVE_HALVES;
  localparam int HW   = $clog2(MAXH + 1);
  localparam logic [HW-1:0] LEAD_LAST  = HW'(LEAD_HALVES - 1);
  localparam logic [HW-1:0] DRIVE_LAST = HW'(DRIVE_HALVES - 1);
  localparam logic [HW-1:0] H_ONE      = HW'(1);

  nk_state_e     st_q, st_nx;
  logic [HW-1:0] h_q, h_nx;

  always_comb begin
    st_nx = st_q;
    h_nx  = h_q;
    unique case (st_q)
      NK_IDLE: begin
        if (start) begin
          st_nx = NK_LEAD;
          h_nx  = '0;
        end
      end
      NK_LEAD: begin
        if (half_tick) begin
          if (h_q == LEAD_LAST) begin
            st_nx = NK_DRIVE;
            h_nx  = '0;
          end else begin
            h_nx = h_q + H_ONE;
          end
        end
      end
      NK_DRIVE: begin
        if (half_tick) begin
          if (h_q == DRIVE_LAST) begin
            st_nx = NK_IDLE;
            h_nx  = '0;
          end else begin
            h_nx = h_q + H_ONE;
          end
        end
      end
      default: begin
        st_nx = NK_IDLE;
        h_nx  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= NK_IDLE;
      h_q  <= '0;
    end else begin
      st_q <= st_nx;
      h_q  <= h_nx;
    end
  end

  assign busy    = (st_q != NK_IDLE);
  assign drive_o = (st_q == NK_DRIVE);

  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_o) |-> $past(half_tick));

  p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_o) |-> $past(half_tick));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !drive_o);

endmodule

// File: rtl/nack_ctl.sv
module nack_ctl
  import nack_ctl_pkg::*;
#(
  parameter int ITER_W       = 3,
  parameter int LEAD_HALVES  = 1,
  parameter int DRIVE_HALVES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  output logic              char_ready,
  input  logic              char_perr,
  input  logic              inhibit_nack,
  input  logic              limit_en,
  input  logic [ITER_W-1:0] max_retries,
  input  logic              half_tick,
  input  logic              clr_status,
  output logic              nack_drive,
  output logic              iter_flag
);

  logic        take;
  logic        busy;
  nk_verdict_t verdict;

  assign char_ready = !busy;
  assign take       = char_valid && char_ready;

  nack_decide #(.ITER_W(ITER_W)) u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .perr     (char_perr),
    .inhibit  (inhibit_nack),
    .limit_en (limit_en),
    .max_iter (max_retries),
    .clr      (clr_status),
    .verdict  (verdict),
    .flag_o   (iter_flag)
  );

  nack_timer #(.LEAD_HALVES(LEAD_HALVES), .DRIVE_HALVES(DRIVE_HALVES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take && verdict.fire),
    .half_tick (half_tick),
    .busy      (busy),
    .drive_o   (nack_drive)
  );

  p_inhibit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && char_perr && inhibit_nack |=> char_ready);

  p_plain_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && char_perr && !inhibit_nack && !limit_en |=> !char_ready);

  p_limit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && verdict.hit_limit |=> char_ready && iter_flag);

  p_good_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !char_perr |=> char_ready);

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_ready && !clr_status |=> $stable(iter_flag));

endmodule

// File: tb/nack_ctl_test.sv
`timescale 1ns/1ps
module nack_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0;
  logic       char_ready;
  logic       char_perr = 1'b0;
  logic       inhibit_nack = 1'b0;
  logic       limit_en = 1'b0;
  logic [2:0] max_retries = 3'd0;
  logic       half_tick = 1'b0;
  logic       clr_status = 1'b0;
  logic       nack_drive;
  logic       iter_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nack_ctl uut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_ready(char_ready),
    .char_perr(char_perr), .inhibit_nack(inhibit_nack), .limit_en(limit_en),
    .max_retries(max_retries), .half_tick(half_tick), .clr_status(clr_status),
    .nack_drive(nack_drive), .iter_flag(iter_flag)
  );

  // {clr, inhibit, limit, max[2:0], perr, expect_pulse, expect_flag}
  localparam int NV = 15;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_0_1_010_1_1_0, 9'b0_0_1_010_1_1_0, 9'b0_0_1_010_1_0_1,
    9'b0_0_1_010_1_0_1, 9'b0_0_1_010_0_0_1, 9'b0_0_1_010_1_1_1,
    9'b1_0_1_000_1_0_1, 9'b1_0_0_000_1_1_0, 9'b0_1_0_000_1_0_0,
    9'b0_1_1_000_1_0_0, 9'b1_0_1_001_1_1_0, 9'b0_0_1_001_0_0_0,
    9'b0_0_1_001_1_1_0, 9'b0_0_1_001_1_0_1, 9'b1_0_1_111_1_1_0
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input bit perr);
    @(negedge clk);
    char_valid = 1'b1;
    char_perr  = perr;
    @(negedge clk);
    char_valid = 1'b0;
    char_perr  = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
  endtask

  task automatic clear;
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  task automatic drain;
    for (int k = 0; k < 8 && !char_ready; k++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(nack_drive == 1'b0, "R1 drive", nack_drive, 0);
    check(iter_flag == 1'b0, "R1 flag", iter_flag, 0);
    check(char_ready == 1'b1, "R1 ready", char_ready, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [8:0] v;
      v = VEC[i];
      @(negedge clk);
      inhibit_nack = v[7];
      limit_en     = v[6];
      max_retries  = v[5:3];
      if (v[8]) clear();
      send(v[2]);
      if (v[7])       tag = "R2";
      else if (!v[2]) tag = "R6";
      else if (!v[6]) tag = "R3";
      else if (v[1])  tag = "R4";
      else            tag = "R5";
      check((!char_ready) == v[1], tag, !char_ready, v[1]);
      check(iter_flag == v[0], {tag, " R8 flag"}, iter_flag, v[0]);
      drain();
    end

    // R7 pulse timing, R9 back-pressure
    inhibit_nack = 1'b0; limit_en = 1'b0;
    clear();
    send(1'b1);
    check(char_ready == 1'b0, "R9 busy", char_ready, 0);
    check(nack_drive == 1'b0, "R7 lead", nack_drive, 0);
    repeat (3) @(negedge clk);
    check(nack_drive == 1'b0, "R7 waits tick", nack_drive, 0);
    tick();
    check(nack_drive == 1'b1, "R7 rise", nack_drive, 1);
    tick();
    check(nack_drive == 1'b1, "R7 hold", nack_drive, 1);
    check(char_ready == 1'b0, "R9 busy in drive", char_ready, 0);
    tick();
    check(nack_drive == 1'b0, "R7 fall", nack_drive, 0);
    check(char_ready == 1'b1, "R9 released", char_ready, 1);

    // R9 a character offered while busy is not counted
    limit_en = 1'b1; max_retries = 3'd2;
    clear();
    send(1'b1);
    send(1'b1);
    drain();
    send(1'b1);
    check(char_ready == 1'b0, "R9 busy char ignored", char_ready, 0);
    drain();
    send(1'b1);
    check(iter_flag == 1'b1, "R5 ceiling after ignored", iter_flag, 1);

    // R8 clear in the same cycle as a character
    max_retries = 3'd1;
    @(negedge clk);
    clr_status = 1'b1; char_valid = 1'b1; char_perr = 1'b1;
    @(negedge clk);
    clr_status = 1'b0; char_valid = 1'b0; char_perr = 1'b0;
    check(iter_flag == 1'b0, "R8 same-cycle clear", iter_flag, 0);
    check(char_ready == 1'b0, "R8 count cleared first", char_ready, 0);
    drain();
    repeat (4) @(negedge clk);
    check(iter_flag == 1'b0, "R8 stays clear", iter_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule